// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave Model

This block behaves as a three-wire serial EEPROM that holds 16-bit words. A master raises chip select, clocks a start bit, a two-bit opcode and an address into the data-in pin on rising serial-clock edges, and reads or writes one word. The array depth is a parameter, either 64 or 256 words. The address length follows the depth: 6 bits or 8 bits. The block drives data-out low as soon as the last address bit has been taken. A master that counts address bits until that zero appears can therefore tell which size is fitted.

The serial pins are sampled in the system clock domain. Each serial-clock half period must last several system clocks. Stored words start from a computed pattern, so no external file is needed. A committed write raises a busy flag for a fixed number of system clocks. While that flag is high, start bits are refused.

Top module: `mw_eeprom_model`

## Requirements
- R1: After synchronous reset, `dout` is 1 and `busy` is 0.
- R2: `dout` reads 1 while chip select is low, and on every serial-clock rise from the first start-bit candidate up to, but not including, the last address bit.
- R3: On the serial-clock rise that delivers the last address bit, `dout` goes to 0. This dummy zero appears whatever the opcode.
- R4: The address field is `$clog2(WORDS)` bits long, so it is 6 bits for 64 words and 8 bits for 256 words. Address bits are sent MSB first.
- R5: Opcode `10` is a read. On the 16 rises that follow the dummy zero, `dout` carries the addressed word MSB first. After those 16 bits `dout` returns to 1.
- R6: After configuration, word n holds n XOR 16'hA5A5.
- R7: Opcode `01` is a write. Data bits follow the address MSB first. The word is stored when chip select falls, and only if exactly 16 data bits arrived.
- R8: A write that delivered fewer or more than 16 data bits leaves the array unchanged.
- R9: Dropping chip select at any point aborts the command. The next command is decoded from its start bit.
- R10: While idle with chip select high, 0 bits on data-in are ignored until a 1 start bit arrives.
- R11: A stored write raises `busy` for `BUSY_CYCLES` system clocks. While `busy` is high, start bits are ignored.
- R12: Opcodes `00` and `11` produce the dummy zero and then `dout` = 1. They change no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sk | input | 1 | Serial clock from the master |
| cs | input | 1 | Chip select, active high |
| di | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master (1 models an undriven line) |
| busy | output | 1 | High while a stored write is programming |

## Verification
A decoder that miscounts address bits moves the dummy zero. That error shows on `dout` on the very serial-clock rise that should carry the last address bit, so the 64-word and 256-word instances are driven side by side on one bus to compare where the zero falls. A corrupt shift register or a read address that is off by one shows within the 16 data bits of the next read. A write committed under the wrong bit count only shows on a later read of the same word, so the bench reads back every address it has touched.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_ADDR,
    S_RD,
    S_WR,
    S_SKIP
  } mw_state_e;

  localparam int        OP_BITS  = 2;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mw_sync.sv
// Samples the serial pins into the system clock domain and flags edges.
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sk,
  input  logic cs,
  input  logic di,
  output logic sk_rise,
  output logic cs_lvl,
  output logic cs_fall,
  output logic di_lvl
);
  // bit 0 = sk, bit 1 = cs, bit 2 = di
  logic [2:0] pipe [STAGES];
  logic [1:0] prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 3'b000;
        else     pipe[0] <= {di, cs, sk};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= 3'b000;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 2'b00;
    else     prev <= pipe[STAGES-1][1:0];
  end

  assign sk_rise = pipe[STAGES-1][0] & ~prev[0];
  assign cs_lvl  = pipe[STAGES-1][1];
  assign cs_fall = prev[1] & ~pipe[STAGES-1][1];
  assign di_lvl  = pipe[STAGES-1][2];
endmodule

// File: rtl/mw_array.sv
// Word storage: one synchronous write port and one registered read port.
module mw_array #(
  parameter int              DEPTH    = 256,
  parameter int              DW       = 16,
  parameter logic [DW-1:0]   INIT_KEY = 16'hA5A5,
  localparam int             AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  typedef logic [DW-1:0] mem_t [DEPTH];

  function automatic mem_t seed_fn();
    mem_t m;
    for (int i = 0; i < DEPTH; i++) m[i] = DW'(i) ^ INIT_KEY;
    return m;
  endfunction

  mem_t mem = seed_fn();

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mw_decoder.sv
// Command decoder: start bit, opcode, address, then a read shift-out or a write capture.
module mw_decoder
  import mw_pkg::*;
#(
  parameter int  WORD_W      = 16,
  parameter int  ADDR_W      = 8,
  parameter int  BUSY_CYCLES = 32,
  localparam int CW          = $clog2(WORD_W + 2),
  localparam int BW          = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sk_rise,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              di,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              dout,
  output logic              busy,
  output mw_state_e         state_o,
  output logic [CW-1:0]     cnt_o
);
  localparam logic [CW-1:0] OPC_LAST  = CW'(OP_BITS - 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
  localparam logic [CW-1:0] DATA_FULL = CW'(WORD_W);
  localparam logic [CW-1:0] DATA_OVER = CW'(WORD_W + 1);

  mw_state_e         state;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr_r;
  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     busy_cnt;
  logic              we_r;
  logic              dout_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      opc      <= '0;
      addr_r   <= '0;
      shreg    <= '0;
      busy_cnt <= '0;
      we_r     <= 1'b0;
      dout_r   <= 1'b1;
    end else begin
      we_r <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (cs_fall && state == S_WR && cnt == DATA_FULL) begin
        we_r     <= 1'b1;
        busy_cnt <= BW'(BUSY_CYCLES);
      end
      if (!cs_lvl) begin
        state  <= S_IDLE;
        cnt    <= '0;
        dout_r <= 1'b1;
      end else if (sk_rise) begin
        unique case (state)
          S_IDLE: begin
            if (di && busy_cnt == '0) begin
              state <= S_OPC;
              cnt   <= '0;
            end
          end
          S_OPC: begin
            opc <= {opc[0], di};
            if (cnt == OPC_LAST) begin
              cnt   <= '0;
              state <= S_ADDR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ADDR: begin
            addr_r <= {addr_r[ADDR_W-2:0], di};
            if (cnt == ADDR_LAST) begin
              cnt    <= '0;
              dout_r <= 1'b0;
              if (opc == OP_READ)       state <= S_RD;
              else if (opc == OP_WRITE) state <= S_WR;
              else                      state <= S_SKIP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RD: begin
            if (cnt == '0) begin
              dout_r <= rd_word[WORD_W-1];
              shreg  <= {rd_word[WORD_W-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end else if (cnt < DATA_FULL) begin
              dout_r <= shreg[WORD_W-1];
              shreg  <= {shreg[WORD_W-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end else begin
              dout_r <= 1'b1;
            end
          end
          S_WR: begin
            dout_r <= 1'b1;
            shreg  <= {shreg[WORD_W-2:0], di};
            if (cnt != DATA_OVER) cnt <= cnt + 1'b1;
          end
          default: dout_r <= 1'b1;
        endcase
      end
    end
  end

  assign addr    = addr_r;
  assign wr_en   = we_r;
  assign wr_data = shreg;
  assign dout    = dout_r;
  assign busy    = (busy_cnt != '0);
  assign state_o = state;
  assign cnt_o   = cnt;
endmodule

// File: rtl/mw_eeprom_model.sv
// Top: serial EEPROM slave with a parameterised word count.
module mw_eeprom_model
  import mw_pkg::*;
#(
  parameter int                WORDS       = 256,
  parameter int                WORD_W      = 16,
  parameter logic [WORD_W-1:0] INIT_KEY    = 16'hA5A5,
  parameter int                BUSY_CYCLES = 32,
  parameter int                SYNC_STAGES = 2,
  localparam int               ADDR_W      = $clog2(WORDS),
  localparam int               CW          = $clog2(WORD_W + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic sk,
  input  logic cs,
  input  logic di,
  output logic dout,
  output logic busy
);
  logic              sk_rise;
  logic              cs_lvl;
  logic              cs_fall;
  logic              di_lvl;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_word;
  mw_state_e         state;
  logic [CW-1:0]     cnt;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sk     (sk),
    .cs     (cs),
    .di     (di),
    .sk_rise(sk_rise),
    .cs_lvl (cs_lvl),
    .cs_fall(cs_fall),
    .di_lvl (di_lvl)
  );

  mw_decoder #(
    .WORD_W     (WORD_W),
    .ADDR_W     (ADDR_W),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_dec (
    .clk    (clk),
    .rst    (rst),
    .sk_rise(sk_rise),
    .cs_lvl (cs_lvl),
    .cs_fall(cs_fall),
    .di     (di_lvl),
    .rd_word(rd_word),
    .addr   (addr),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .dout   (dout),
    .busy   (busy),
    .state_o(state),
    .cnt_o  (cnt)
  );

  mw_array #(
    .DEPTH   (WORDS),
    .DW      (WORD_W),
    .INIT_KEY(INIT_KEY)
  ) u_mem (
    .clk  (clk),
    .we   (wr_en),
    .addr (addr),
    .wdata(wr_data),
    .rdata(rd_word)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          dout,
  input logic          busy,
  input logic          cs_lvl,
  input logic          sk_rise,
  input logic          wr_en,
  input mw_state_e     state,
  input logic [CW-1:0] cnt
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (dout && !busy));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl |=> dout);

  // R3
  dummy_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_lvl && sk_rise && state == S_ADDR && cnt == CW'(ADDR_W - 1)) |=> !dout);

  // R7
  commit_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !cs_lvl);

  // R11
  busy_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  // R11
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> state == S_IDLE);
endmodule

bind mw_eeprom_model mw_eeprom_chk #(.ADDR_W(ADDR_W), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .dout   (dout),
  .busy   (busy),
  .cs_lvl (cs_lvl),
  .sk_rise(sk_rise),
  .wr_en  (wr_en),
  .state  (state),
  .cnt    (cnt)
);

// File: tb/mw_eeprom_model_bench.sv
module mw_eeprom_model_bench;
  localparam int BUSY = 64;
  localparam int NVEC = 12;
  // {kind[1:0], addr[7:0], data[15:0]}: kind 0 = read of seeded word, 1 = write, 2 = read after write
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 16'h0000},
    {2'd0, 8'hFF, 16'h0000},
    {2'd0, 8'h3C, 16'h0000},
    {2'd1, 8'h3C, 16'hDEAD},
    {2'd2, 8'h3C, 16'h0000},
    {2'd1, 8'h00, 16'h0001},
    {2'd2, 8'h00, 16'h0000},
    {2'd1, 8'hFF, 16'h8000},
    {2'd2, 8'hFF, 16'h0000},
    {2'd0, 8'h81, 16'h0000},
    {2'd1, 8'h80, 16'h5A5A},
    {2'd2, 8'h80, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sk = 1'b0, cs = 1'b0, di = 1'b0;
  logic dout, busy, dout_s, busy_s;
  logic [15:0] model [256];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mw_eeprom_model #(.WORDS(256), .BUSY_CYCLES(BUSY)) u_mw_eeprom_model (
    .clk(clk), .rst(rst), .sk(sk), .cs(cs), .di(di), .dout(dout), .busy(busy)
  );

  mw_eeprom_model #(.WORDS(64), .BUSY_CYCLES(BUSY)) u_small (
    .clk(clk), .rst(rst), .sk(sk), .cs(cs), .di(di), .dout(dout_s), .busy(busy_s)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
  endtask

  // Sends n bits MSB first; records dout of both instances after each rise.
  task automatic xfer(input int n, input logic [63:0] bits,
                      output logic [63:0] ob, output logic [63:0] os);
    ob = '1;
    os = '1;
    cs = 1'b1;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      di = bits[i];
      wait_clk(4);
      sk = 1'b1;
      wait_clk(8);
      ob[i] = dout;
      os[i] = dout_s;
      sk = 1'b0;
      wait_clk(4);
    end
    cs = 1'b0;
    di = 1'b0;
    wait_clk(8);
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [63:0] ob, os;
    wait_ready();
    xfer(27, {37'b0, 1'b1, 2'b10, a, 16'h0000}, ob, os);
    chk("R2 command phase high", 32'(ob[26:17]), 32'h3FF);
    chk("R3 dummy zero", 32'(ob[16]), 32'h0);
    chk(req, 32'(ob[15:0]), 32'(model[a]));
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    logic [63:0] ob, os;
    wait_ready();
    xfer(27, {37'b0, 1'b1, 2'b01, a, d}, ob, os);
    model[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] ob, os;
    for (int i = 0; i < 256; i++) model[i] = 16'(i) ^ 16'hA5A5;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    chk("R1 dout after reset", 32'(dout), 32'h1);
    chk("R1 busy after reset", 32'(busy), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][25:24] == 2'd1)      do_write(VEC[v][23:16], VEC[v][15:0]);
      else if (VEC[v][25:24] == 2'd0) do_read(VEC[v][23:16], "R6 seeded word");
      else                            do_read(VEC[v][23:16], "R7 written word");
    end

    // R4: a 6-bit address ends the command on the 64-word part only
    wait_ready();
    xfer(25, {39'b0, 1'b1, 2'b10, 6'h2A, 16'h0000}, ob, os);
    chk("R4 small dummy after 6 address bits", 32'(os[16]), 32'h0);
    chk("R4 small high before dummy", 32'(os[17]), 32'h1);
    chk("R4 large still receiving address", 32'(ob[16]), 32'h1);
    chk("R5 small read MSB first", 32'(os[15:0]), 32'(16'h002A ^ 16'hA5A5));

    // R5: data line returns high after 16 bits
    wait_ready();
    xfer(29, {35'b0, 1'b1, 2'b10, 8'h3C, 16'h0000, 2'b00}, ob, os);
    chk("R5 word on read", 32'(ob[17:2]), 32'(model[8'h3C]));
    chk("R5 high after 16 bits", 32'(ob[1:0]), 32'h3);

    // R8: short and long writes are dropped
    wait_ready();
    xfer(26, {38'b0, 1'b1, 2'b01, 8'h10, 15'h1234}, ob, os);
    chk("R8 busy after short write", 32'(busy), 32'h0);
    do_read(8'h10, "R8 short write ignored");
    xfer(28, {36'b0, 1'b1, 2'b01, 8'h10, 17'h1FFFF}, ob, os);
    do_read(8'h10, "R8 long write ignored");

    // R9: abort in the opcode, then in the middle of a read, then a clean read
    xfer(2, {62'b0, 2'b11}, ob, os);
    do_read(8'h55, "R9 read after opcode abort");
    xfer(18, {46'b0, 1'b1, 2'b10, 8'h20, 7'h00}, ob, os);
    do_read(8'h21, "R9 read after mid-read abort");

    // R10: leading zeros before the start bit
    xfer(30, {34'b0, 3'b000, 1'b1, 2'b10, 8'h77, 16'h0000}, ob, os);
    chk("R10 dummy after leading zeros", 32'(ob[16]), 32'h0);
    chk("R10 word after leading zeros", 32'(ob[15:0]), 32'(model[8'h77]));

    // R12: opcode 11 gives dummy zero then high, and changes nothing
    xfer(27, {37'b0, 1'b1, 2'b11, 8'h44, 16'h0000}, ob, os);
    chk("R12 dummy on other opcode", 32'(ob[16]), 32'h0);
    chk("R12 high after dummy", 32'(ob[15:0]), 32'hFFFF);
    do_read(8'h44, "R12 word unchanged");

    // R11: busy after a stored write, and a read during busy is ignored
    do_write(8'h90, 16'hBEEF);
    chk("R11 busy after commit", 32'(busy), 32'h1);
    xfer(27, {37'b0, 1'b1, 2'b10, 8'h00, 16'h0000}, ob, os);
    chk("R11 command ignored while busy", 32'(ob[26:0]), 32'h7FFFFFF);
    wait_ready();
    chk("R11 busy clears", 32'(busy), 32'h0);
    do_read(8'h90, "R7 written word after busy");

    // R2: idle line while deselected
    chk("R2 idle high", 32'(dout), 32'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule